// File: doc/BRIEF.md
# Received Pause Transmit Inhibitor

This block watches the byte stream of received frames and decides, at the end of each frame, whether that frame was a flow-control pause request meant for this station. A frame qualifies when its destination is either the reserved flow-control multicast group or the station's own individual address, its type field carries the MAC-control value and its opcode is the pause opcode. When a pause qualifies and the frame is reported good, a 16-bit countdown is loaded with the frame's time parameter. The countdown is in slot times: it steps down on each slot tick (512 bit times) and holds at zero.

While the countdown is nonzero the block refuses to start new ordinary transmit frames. A frame already on the wire is not cut short, and the station can still start its own flow-control frames. For every received frame the block also decides whether it should be handed to the receive FIFO. It emits a one-cycle pulse for each accepted pause, which drives an external statistics counter. FCS checking and the FIFO itself sit outside.

Top module: `pause_inhibit_top`

## Requirements
- R1: A frame is a pause when all of the following hold. It carries at least 18 bytes. Bytes 0-5 (the destination) equal 01-80-C2-00-00-01 or `station_addr` (most significant byte first). Bytes 12-13 are 88 then 08. Bytes 14-15 are 00 then 01. Its end strobe `rx_eof` comes with `rx_good` high.
- R2: For an accepted pause, the countdown takes the time parameter from bytes 16 (high) and 17 (low). The new value governs `tx_inhibit` from the cycle after `rx_eof`.
- R3: The countdown falls by one on each cycle with `slot_tick` high, and it stays at zero once it gets there.
- R4: A pause that arrives while the countdown is running replaces the countdown with its own parameter. If a load and a tick fall in the same cycle, the load wins.
- R5: A pause with a time parameter of zero clears the countdown and drops `tx_inhibit` on the next cycle.
- R6: `tx_inhibit` is high exactly while the countdown is nonzero. `tx_start_ok` equals `tx_start_req AND (NOT tx_inhibit OR tx_req_is_fc)`.
- R7: `paused` is high when the countdown is nonzero and `tx_busy` is low.
- R8: `fifo_room` has no effect on whether a pause loads the countdown or on the accepted-pause pulse.
- R9: `rx_fwd_vld` pulses once, one cycle after each `rx_eof`. With it, `rx_fwd` is 0 for a bad frame or when `fifo_room` is low. A pause to the multicast address is forwarded only if `cfg_reject_fc` is 0. A pause to the individual address, and any other good frame, is forwarded whenever there is room.
- R10: `pause_rcvd` is a one-cycle pulse, one cycle after `rx_eof`, for each accepted pause and for no other frame.
- R11: A frame whose destination, type or opcode mismatches, one shorter than 18 bytes, or one ended with `rx_good` low leaves the countdown unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| station_addr | input | 48 | Individual address of the station |
| cfg_reject_fc | input | 1 | Do not forward pauses sent to the multicast address |
| fifo_room | input | 1 | Receive FIFO can take the current frame |
| rx_byte_vld | input | 1 | A received byte is present on rx_byte |
| rx_byte | input | 8 | Received byte, destination first |
| rx_eof | input | 1 | End-of-frame strobe, in a cycle with no byte |
| rx_good | input | 1 | Frame good qualifier, sampled with rx_eof |
| slot_tick | input | 1 | One pulse per slot time |
| tx_start_req | input | 1 | Transmitter wants to start a frame |
| tx_req_is_fc | input | 1 | The requested frame is a flow-control frame |
| tx_busy | input | 1 | A transmit frame is in progress |
| tx_start_ok | output | 1 | Start of the requested frame is allowed |
| tx_inhibit | output | 1 | New ordinary frames are blocked |
| paused | output | 1 | Held off and idle |
| rx_fwd_vld | output | 1 | Forwarding decision valid |
| rx_fwd | output | 1 | Pass the frame to the FIFO |
| pause_rcvd | output | 1 | Accepted pause pulse for the statistics counter |

## Verification
The embedded properties check the countdown's per-cycle laws on every cycle. These are: a load wins and takes the parameter, a tick steps the count down, the count stays at zero, and the count holds when idle. They also check that no ordinary start is granted while the count is nonzero, that the multicast reject and the missing room veto forwarding, and that each accepted-pause pulse follows a good end strobe. What only the bench scenarios can show is the byte-level recognition: address, type, opcode and length mismatches, the big-endian assembly of the time parameter, and the way reloads, XON frames and ticks interleave over whole frames against an independent model of the countdown.

// File: rtl/pause_pkg.sv
package pause_pkg;
    // destination class of the current frame
    typedef enum logic [1:0] {
        DA_OTHER = 2'd0,
        DA_GROUP = 2'd1,
        DA_OWN   = 2'd2
    } da_class_e;

    localparam logic [47:0] FC_GROUP_ADDR = 48'h0180_C200_0001;
    localparam logic [15:0] MAC_CTRL_TYPE = 16'h8808;
    localparam logic [15:0] PAUSE_OPCODE  = 16'h0001;
endpackage

// File: rtl/pause_rx_parser.sv
module pause_rx_parser
    import pause_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic              byte_vld_i,
    input  logic [7:0]        byte_i,
    input  logic              eof_i,
    output logic              is_pause_o,
    output da_class_e         da_class_o,
    output logic [TIME_W-1:0] tval_o
);
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int TYPE_OFS   = 2 * ADDR_BYTES;
    localparam int OP_OFS     = TYPE_OFS + 2;
    localparam int TIME_OFS   = OP_OFS + 2;
    localparam int HDR_BYTES  = TIME_OFS + TIME_W / 8;
    localparam int CNT_W      = $clog2(HDR_BYTES + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  idx;
        logic              grp;
        logic              own;
        logic              typ;
        logic              op;
        logic [TIME_W-1:0] tval;
    } prs_t;

    prs_t st_d, st_q;
    logic [7:0] grp_b, own_b, typ_b, op_b;

    // expected byte for the current header position
    always_comb begin
        grp_b = '0;
        own_b = '0;
        for (int k = 0; k < ADDR_BYTES; k++) begin
            if (st_q.idx == CNT_W'(k)) begin
                grp_b = FC_GROUP_ADDR[8*(ADDR_BYTES-1-k) +: 8];
                own_b = station_addr[8*(ADDR_BYTES-1-k) +: 8];
            end
        end
        typ_b = (st_q.idx == CNT_W'(TYPE_OFS)) ? MAC_CTRL_TYPE[15:8] : MAC_CTRL_TYPE[7:0];
        op_b  = (st_q.idx == CNT_W'(OP_OFS))   ? PAUSE_OPCODE[15:8]  : PAUSE_OPCODE[7:0];
    end

    always_comb begin
        st_d = st_q;
        if (eof_i) begin
            st_d.idx = '0;
        end else if (byte_vld_i) begin
            if (st_q.idx < CNT_W'(HDR_BYTES)) begin
                st_d.idx = st_q.idx + CNT_W'(1);
            end
            if (st_q.idx < CNT_W'(ADDR_BYTES)) begin
                st_d.grp = ((st_q.idx == '0) || st_q.grp) && (byte_i == grp_b);
                st_d.own = ((st_q.idx == '0) || st_q.own) && (byte_i == own_b);
            end
            if (st_q.idx == CNT_W'(TYPE_OFS)) begin
                st_d.typ = (byte_i == typ_b);
            end else if (st_q.idx == CNT_W'(TYPE_OFS + 1)) begin
                st_d.typ = st_q.typ && (byte_i == typ_b);
            end
            if (st_q.idx == CNT_W'(OP_OFS)) begin
                st_d.op = (byte_i == op_b);
            end else if (st_q.idx == CNT_W'(OP_OFS + 1)) begin
                st_d.op = st_q.op && (byte_i == op_b);
            end
            if ((st_q.idx >= CNT_W'(TIME_OFS)) && (st_q.idx < CNT_W'(HDR_BYTES))) begin
                st_d.tval = {st_q.tval[TIME_W-9:0], byte_i};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (st_q.own) begin
            da_class_o = DA_OWN;
        end else if (st_q.grp) begin
            da_class_o = DA_GROUP;
        end else begin
            da_class_o = DA_OTHER;
        end
        is_pause_o = eof_i && (st_q.idx == CNT_W'(HDR_BYTES)) && (st_q.grp || st_q.own)
                     && st_q.typ && st_q.op;
        tval_o     = st_q.tval;
    end

    AST_EOF_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        eof_i |=> (st_q.idx == '0)) else $error("parser index not restarted"); // R1
endmodule

// File: rtl/pause_fwd_ctrl.sv
module pause_fwd_ctrl
    import pause_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      eof_i,
    input  logic      good_i,
    input  logic      is_pause_i,
    input  da_class_e da_class_i,
    input  logic      room_i,
    input  logic      reject_i,
    output logic      load_o,
    output logic      fwd_vld_o,
    output logic      fwd_o,
    output logic      pulse_o
);
    typedef struct packed {
        logic fwd_vld;
        logic fwd;
        logic pulse;
    } fwd_t;

    fwd_t st_d, st_q;
    logic accept;
    logic group_veto;

    always_comb begin
        accept     = eof_i && good_i && is_pause_i;
        group_veto = is_pause_i && (da_class_i != DA_OWN) && reject_i;
        st_d.fwd_vld = eof_i;
        st_d.fwd     = eof_i && good_i && room_i && !group_veto;
        st_d.pulse   = accept;
        load_o       = accept;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fwd_vld_o = st_q.fwd_vld;
    assign fwd_o     = st_q.fwd;
    assign pulse_o   = st_q.pulse;

    AST_GROUP_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_i && is_pause_i && da_class_i == DA_GROUP && reject_i) |=> !fwd_o)
        else $error("rejected group pause forwarded"); // R9
    AST_NO_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_i && !room_i) |=> !fwd_o) else $error("forward without room"); // R9
    AST_PULSE_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_i && !good_i) |=> !pulse_o) else $error("pulse on bad frame"); // R10
endmodule

// File: rtl/pause_slot_timer.sv
module pause_slot_timer #(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [TIME_W-1:0] tval_i,
    input  logic              tick_i,
    output logic              active_o
);
    typedef struct packed {
        logic [TIME_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cnt = tval_i;
        end else if (tick_i && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - TIME_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = (st_q.cnt != '0);

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.cnt == $past(tval_i))) else $error("load lost"); // R4
    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && tick_i && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - TIME_W'(1)))
        else $error("tick step wrong"); // R3
    AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && st_q.cnt == '0) |=> (st_q.cnt == '0)) else $error("count left zero"); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !tick_i) |=> $stable(st_q.cnt)) else $error("count moved idle"); // R3
endmodule

// File: rtl/pause_tx_gate.sv
module pause_tx_gate (
    input  logic active_i,
    input  logic start_req_i,
    input  logic req_is_fc_i,
    input  logic busy_i,
    output logic inhibit_o,
    output logic start_ok_o,
    output logic paused_o
);
    always_comb begin
        inhibit_o  = active_i;
        start_ok_o = start_req_i && (!active_i || req_is_fc_i);
        paused_o   = active_i && !busy_i;
    end
endmodule

// File: rtl/pause_inhibit_top.sv
module pause_inhibit_top
    import pause_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic              cfg_reject_fc,
    input  logic              fifo_room,
    input  logic              rx_byte_vld,
    input  logic [7:0]        rx_byte,
    input  logic              rx_eof,
    input  logic              rx_good,
    input  logic              slot_tick,
    input  logic              tx_start_req,
    input  logic              tx_req_is_fc,
    input  logic              tx_busy,
    output logic              tx_start_ok,
    output logic              tx_inhibit,
    output logic              paused,
    output logic              rx_fwd_vld,
    output logic              rx_fwd,
    output logic              pause_rcvd
);
    logic              is_pause;
    da_class_e         da_class;
    logic [TIME_W-1:0] tval;
    logic              load;
    logic              active;

    pause_rx_parser #(.ADDR_W(ADDR_W), .TIME_W(TIME_W)) u_parser (
        .clk(clk), .rst_n(rst_n), .station_addr(station_addr),
        .byte_vld_i(rx_byte_vld), .byte_i(rx_byte), .eof_i(rx_eof),
        .is_pause_o(is_pause), .da_class_o(da_class), .tval_o(tval)
    );

    pause_fwd_ctrl u_fwd (
        .clk(clk), .rst_n(rst_n), .eof_i(rx_eof), .good_i(rx_good),
        .is_pause_i(is_pause), .da_class_i(da_class), .room_i(fifo_room),
        .reject_i(cfg_reject_fc), .load_o(load), .fwd_vld_o(rx_fwd_vld),
        .fwd_o(rx_fwd), .pulse_o(pause_rcvd)
    );

    pause_slot_timer #(.TIME_W(TIME_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(load), .tval_i(tval),
        .tick_i(slot_tick), .active_o(active)
    );

    pause_tx_gate u_gate (
        .active_i(active), .start_req_i(tx_start_req), .req_is_fc_i(tx_req_is_fc),
        .busy_i(tx_busy), .inhibit_o(tx_inhibit), .start_ok_o(tx_start_ok),
        .paused_o(paused)
    );

    AST_NO_PLAIN_START: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start_ok && !tx_req_is_fc) |-> !active) else $error("start while paused"); // R6
    AST_PULSE_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        pause_rcvd |-> rx_fwd_vld) else $error("pulse without frame end"); // R10
endmodule

// File: tb/sim_pause_inhibit_top.sv
module sim_pause_inhibit_top;
    localparam logic [47:0] OWN_ADDR = 48'h02AA_BBCC_DDEE;
    localparam logic [47:0] GRP_ADDR = 48'h0180_C200_0001;
    localparam logic [47:0] OTH_ADDR = 48'h02AA_BBCC_DDEF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_reject_fc = 1'b0, fifo_room = 1'b1;
    logic rx_byte_vld = 1'b0, rx_eof = 1'b0, rx_good = 1'b0;
    logic [7:0] rx_byte = '0;
    logic slot_tick = 1'b0, tx_start_req = 1'b0, tx_req_is_fc = 1'b0, tx_busy = 1'b0;
    logic tx_start_ok, tx_inhibit, paused, rx_fwd_vld, rx_fwd, pause_rcvd;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    int tick_mode = 0; // 0 random, 1 off, 2 on

    // bench model of the countdown
    logic [15:0] mcount = '0;
    logic m_load = 1'b0;
    logic [15:0] m_time = '0;

    // frame fields
    logic [47:0] cur_da;
    bit cur_type_ok, cur_op_ok;
    logic [15:0] cur_time;

    always #10 clk = ~clk;

    pause_inhibit_top u0 (
        .clk(clk), .rst_n(rst_n), .station_addr(OWN_ADDR), .cfg_reject_fc(cfg_reject_fc),
        .fifo_room(fifo_room), .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
        .rx_eof(rx_eof), .rx_good(rx_good), .slot_tick(slot_tick),
        .tx_start_req(tx_start_req), .tx_req_is_fc(tx_req_is_fc), .tx_busy(tx_busy),
        .tx_start_ok(tx_start_ok), .tx_inhibit(tx_inhibit), .paused(paused),
        .rx_fwd_vld(rx_fwd_vld), .rx_fwd(rx_fwd), .pause_rcvd(pause_rcvd)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) mcount <= '0;
        else if (m_load) mcount <= m_time;                       // R2 R4
        else if (slot_tick && mcount != 0) mcount <= mcount - 1; // R3
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R6", "tx_inhibit", int'(tx_inhibit), int'(mcount != 0));
            chk("R7", "paused", int'(paused), int'(mcount != 0 && !tx_busy));
        end
        slot_tick    = (tick_mode == 2) || (tick_mode == 0 && ($urandom % 3 == 0));
        tx_start_req = ($urandom % 2) == 1;
        tx_req_is_fc = ($urandom % 4) == 0;
        tx_busy      = ($urandom % 2) == 1;
        #1;
        if (rst_n && !finished)
            chk("R6", "tx_start_ok", int'(tx_start_ok),
                int'(tx_start_req && (mcount == 0 || tx_req_is_fc)));
    end

    function automatic logic [7:0] fbyte(input int i);
        if (i < 6) return cur_da[8*(5-i) +: 8];
        if (i < 12) return 8'(8'h30 + i);
        if (i == 12) return 8'h88;
        if (i == 13) return cur_type_ok ? 8'h08 : 8'h09;
        if (i == 14) return 8'h00;
        if (i == 15) return cur_op_ok ? 8'h01 : 8'h02;
        if (i == 16) return cur_time[15:8];
        if (i == 17) return cur_time[7:0];
        return 8'(i * 7);
    endfunction

    task automatic send(input logic [47:0] da, input bit type_ok, input bit op_ok,
                        input int len, input logic [15:0] tval, input bit good,
                        input bit room, input bit reject);
        bit exp_pause, exp_fwd;
        cur_da = da; cur_type_ok = type_ok; cur_op_ok = op_ok; cur_time = tval;
        fifo_room = room; cfg_reject_fc = reject;
        exp_pause = good && len >= 18 && (da == GRP_ADDR || da == OWN_ADDR) && type_ok && op_ok;
        exp_fwd = good && room && !(exp_pause && da != OWN_ADDR && reject);
        for (int i = 0; i < len; i++) begin
            rx_byte_vld = 1'b1;
            rx_byte = fbyte(i);
            @(negedge clk);
        end
        rx_byte_vld = 1'b0;
        rx_eof = 1'b1;
        rx_good = good;
        m_load = exp_pause;
        m_time = tval;
        @(negedge clk);
        rx_eof = 1'b0;
        m_load = 1'b0;
        chk("R9", "rx_fwd_vld", int'(rx_fwd_vld), 1);
        chk("R9", "rx_fwd", int'(rx_fwd), int'(exp_fwd));
        chk("R10", "pause_rcvd", int'(pause_rcvd), int'(exp_pause)); // R1 R8 R11
        @(negedge clk);
        chk("R10", "pause_rcvd single", int'(pause_rcvd), 0);
        chk("R9", "rx_fwd_vld single", int'(rx_fwd_vld), 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6", "reset inhibit", int'(tx_inhibit), 0);
        chk("R10", "reset pulse", int'(pause_rcvd), 0);
        chk("R9", "reset fwd_vld", int'(rx_fwd_vld), 0);

        // R2: group pause, timer frozen
        tick_mode = 1;
        send(GRP_ADDR, 1, 1, 18, 16'h0105, 1, 1, 0);
        chk("R2", "inhibit after load", int'(tx_inhibit), 1);
        // R4: reload with a shorter time
        send(OWN_ADDR, 1, 1, 24, 16'h0003, 1, 1, 1);
        tick_mode = 2;
        repeat (4) @(negedge clk);
        chk("R3", "expired after 3 ticks", int'(tx_inhibit), 0);
        // R5: XON clears
        tick_mode = 1;
        send(GRP_ADDR, 1, 1, 18, 16'h4000, 1, 1, 0);
        send(GRP_ADDR, 1, 1, 18, 16'h0000, 1, 1, 0);
        chk("R5", "xon clears", int'(tx_inhibit), 0);
        // R4: load and tick together
        tick_mode = 2;
        send(OWN_ADDR, 1, 1, 20, 16'h0002, 1, 1, 0);
        // R9: rejected group, accepted own, no room (R8 still loads)
        tick_mode = 1;
        send(GRP_ADDR, 1, 1, 18, 16'h0010, 1, 1, 1);
        send(OWN_ADDR, 1, 1, 18, 16'h0020, 1, 1, 1);
        send(GRP_ADDR, 1, 1, 18, 16'h0030, 1, 0, 0);
        chk("R8", "loaded without room", int'(tx_inhibit), 1);
        // R11: ignored frames keep count
        send(GRP_ADDR, 1, 1, 18, 16'h0000, 0, 1, 0);
        send(GRP_ADDR, 0, 1, 18, 16'h0000, 1, 1, 0);
        send(OWN_ADDR, 1, 0, 18, 16'h0000, 1, 1, 0);
        send(OTH_ADDR, 1, 1, 18, 16'h0000, 1, 1, 0);
        send(GRP_ADDR, 1, 1, 17, 16'h0000, 1, 1, 0);
        chk("R11", "count kept", int'(tx_inhibit), 1);

        tick_mode = 0;
        for (int n = 0; n < 300; n++) begin
            int sel;
            logic [47:0] da;
            sel = $urandom % 3;
            da = (sel == 0) ? GRP_ADDR : (sel == 1) ? OWN_ADDR : OTH_ADDR;
            send(da, ($urandom % 6) != 0, ($urandom % 6) != 0, 14 + ($urandom % 12),
                 (($urandom % 5) == 0) ? 16'h0000 : 16'($urandom % 40),
                 ($urandom % 8) != 0, ($urandom % 4) != 0, ($urandom % 2) == 1);
            repeat ($urandom % 4) @(negedge clk);
        end
        tick_mode = 2;
        repeat (60) @(negedge clk);
        chk("R3", "drained", int'(tx_inhibit), 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #3000000;
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL R1 watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule